// File: doc/BRIEF.md
# Nonvolatile Store Command Key Sequencer

This block guards the nonvolatile side of a shadowed memory. It watches the active-low bus controls of the memory port and reduces them to three kinds of completed cycle.

- A pseudo-write has the nonvolatile-enable, chip-enable and write-enable lines all low.
- A RAM write has chip-enable and write-enable low with nonvolatile-enable high.
- A recall has nonvolatile-enable, output-enable and chip-enable low with write-enable high.

Each cycle is recognised when its combined strobe ends (goes inactive), measured after the controls are synchronised to the block clock.

A chain of three pseudo-writes forms an unlock key. The third byte of the key picks the action:

- start a store now;
- arm the automatic power-fail store;
- disarm the automatic power-fail store.

Each completed command leaves the block as a one-clock pulse, which a transfer engine elsewhere acts on. A broken key, an ordinary RAM write or a recall throws the partial key away. A store request is dropped until at least one RAM write has been seen since reset.

Top module: `nv_cmd_seq`

## Requirements
- R1: After reset the key machine is idle, all three command outputs are low and no RAM write is on record.
- R2: The pseudo-write pairs address 155h / data AAh, then 0AAh / 55h, then 155h / 33h produce one pulse on `store_o`. This holds once a RAM write has been seen. Address and data must stay stable from the strobe's release until three clock edges later.
- R3: The same first two steps followed by 155h / CCh pulse `auto_on_o`, and followed by 155h / CDh pulse `auto_off_o`. Neither needs a prior RAM write.
- R4: A key ending in 155h / 33h makes no pulse if no RAM write has occurred since reset. The machine still returns to idle.
- R5: A pseudo-write pair that does not match the expected step sends the machine back to idle. The following pairs must then restart from step one.
- R6: A pair of 155h / AAh arriving at step two or step three counts as a fresh step one.
- R7: At step three, a data byte other than 33h, CCh or CDh produces no pulse. So does any address other than 155h.
- R8: A completed RAM write or recall cycle between key steps returns the machine to idle.
- R9: Each accepted command gives exactly one pulse, one clock wide, on only one output. The pulse is first high after the third rising clock edge that follows the release of the final strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ne_ni | input | 1 | Nonvolatile enable, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 9 | Cycle address |
| data_i | input | 8 | Cycle write data |
| store_o | output | 1 | One-clock request to copy RAM into nonvolatile storage |
| auto_on_o | output | 1 | One-clock request to arm the power-fail store |
| auto_off_o | output | 1 | One-clock request to disarm the power-fail store |

## Verification
A strobe release passes two synchroniser stages. It then passes one edge-detect register and finally the command register. A pulse is therefore due in the third sample window after the release, and it must be gone in the fourth.

The bench drives every pin on the falling clock edge and samples on the falling edge. After each bus cycle it watches six windows and counts every high output sample. This confirms both the due window and the single-cycle width. Expected pulses come from arithmetic over the swept address and data, never from the design.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_STEP1 = 2'd1,
    KS_STEP2 = 2'd2
  } key_state_e;

  typedef struct packed {
    logic store;
    logic auto_on;
    logic auto_off;
  } nv_cmd_t;

  localparam int unsigned CTRL_LINES = 4;

endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else         chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/nvs_cycle_detect.sv
module nvs_cycle_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ne_n_i,
  input  logic ce_n_i,
  input  logic we_n_i,
  input  logic oe_n_i,
  output logic pw_end_o,
  output logic ramwr_end_o,
  output logic recall_end_o
);

  logic pw_act, ramwr_act, recall_act;
  logic pw_q, ramwr_q, recall_q;

  always_comb begin
    pw_act     = !ne_n_i && !ce_n_i && !we_n_i;
    ramwr_act  =  ne_n_i && !ce_n_i && !we_n_i;
    recall_act = !ne_n_i && !ce_n_i &&  we_n_i && !oe_n_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_q     <= 1'b0;
      ramwr_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      pw_q     <= pw_act;
      ramwr_q  <= ramwr_act;
      recall_q <= recall_act;
    end
  end

  assign pw_end_o     = pw_q     && !pw_act;
  assign ramwr_end_o  = ramwr_q  && !ramwr_act;
  assign recall_end_o = recall_q && !recall_act;

  // R8
  end_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pw_q, ramwr_q, recall_q}));

endmodule

// File: rtl/nvs_wr_tracker.sv
module nvs_wr_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ramwr_end_i,
  output logic written_o
);

  logic seen_q, seen_d, seen_en;

  always_comb begin
    seen_en = ramwr_end_i && !seen_q;
    seen_d  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (seen_en) seen_q <= seen_d;
  end

  assign written_o = seen_q;

  // R4
  wr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> seen_q);

endmodule

// File: rtl/nvs_key_fsm.sv
module nvs_key_fsm
  import nvs_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 9'h155,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 9'h0AA,
  parameter logic [DATA_W-1:0] KEY_DATA_A = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_DATA_B = 8'h55,
  parameter logic [DATA_W-1:0] OP_STORE   = 8'h33,
  parameter logic [DATA_W-1:0] OP_AUTO_ON = 8'hCC,
  parameter logic [DATA_W-1:0] OP_AUTO_OFF= 8'hCD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pw_end_i,
  input  logic              abort_i,
  input  logic              written_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output nv_cmd_t           cmd_o
);

  key_state_e state_q, state_d;
  nv_cmd_t    cmd_q, cmd_d;
  logic       first_hit, second_hit, third_addr;

  always_comb begin
    first_hit  = (addr_i == KEY_ADDR_A) && (data_i == KEY_DATA_A);
    second_hit = (addr_i == KEY_ADDR_B) && (data_i == KEY_DATA_B);
    third_addr = (addr_i == KEY_ADDR_A);
  end

  always_comb begin
    state_d = state_q;
    cmd_d   = '0;
    if (abort_i) begin
      state_d = KS_IDLE;
    end else if (pw_end_i) begin
      unique case (state_q)
        KS_IDLE: state_d = first_hit ? KS_STEP1 : KS_IDLE;
        KS_STEP1: begin
          if (second_hit)     state_d = KS_STEP2;
          else if (first_hit) state_d = KS_STEP1;
          else                state_d = KS_IDLE;
        end
        KS_STEP2: begin
          state_d = first_hit ? KS_STEP1 : KS_IDLE;
          if (third_addr) begin
            if (data_i == OP_STORE)    cmd_d.store    = written_i;
            if (data_i == OP_AUTO_ON)  cmd_d.auto_on  = 1'b1;
            if (data_i == OP_AUTO_OFF) cmd_d.auto_off = 1'b1;
          end
        end
        default: state_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KS_IDLE;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
    end
  end

  assign cmd_o = cmd_q;

  // R9
  cmd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_q));

  // R9
  cmd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_q) |=> !(|cmd_q));

  // R2
  cmd_from_step2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_q) |-> $past(state_q == KS_STEP2 && pw_end_i && !abort_i));

  // R4
  store_needs_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q.store |-> written_i);

  // R8
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == KS_IDLE));

  // R5
  step2_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == KS_STEP2 && pw_end_i) |=> (state_q != KS_STEP2));

endmodule

// File: rtl/nv_cmd_seq.sv
module nv_cmd_seq
  import nvs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ne_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              store_o,
  output logic              auto_on_o,
  output logic              auto_off_o
);

  logic [1:0]            rst_sync_q;
  logic                  rst_n_int;
  logic [CTRL_LINES-1:0] ctrl_sync;
  logic                  pw_end, ramwr_end, recall_end, written;
  nv_cmd_t               cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  nvs_sync #(
    .WIDTH  (CTRL_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) ctrl_sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .d_i   ({ne_ni, ce_ni, we_ni, oe_ni}),
    .q_o   (ctrl_sync)
  );

  nvs_cycle_detect detect_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .ne_n_i      (ctrl_sync[3]),
    .ce_n_i      (ctrl_sync[2]),
    .we_n_i      (ctrl_sync[1]),
    .oe_n_i      (ctrl_sync[0]),
    .pw_end_o    (pw_end),
    .ramwr_end_o (ramwr_end),
    .recall_end_o(recall_end)
  );

  nvs_wr_tracker tracker_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .ramwr_end_i(ramwr_end),
    .written_o  (written)
  );

  nvs_key_fsm #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) fsm_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .pw_end_i (pw_end),
    .abort_i  (ramwr_end || recall_end),
    .written_i(written),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .cmd_o    (cmd)
  );

  assign store_o    = cmd.store;
  assign auto_on_o  = cmd.auto_on;
  assign auto_off_o = cmd.auto_off;

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_n_int |-> !(store_o || auto_on_o || auto_off_o));

endmodule

// File: tb/nv_cmd_seq_tb_top.sv
module nv_cmd_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ne_n, ce_n, we_n, oe_n;
  logic [8:0] addr;
  logic [7:0] data;
  logic       store, aon, aoff;

  int n_chk  = 0;
  int n_fail = 0;
  int c_st, c_on, c_off, lat;

  always #4 clk = ~clk;

  nv_cmd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ne_ni(ne_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(data),
    .store_o(store), .auto_on_o(aon), .auto_off_o(aoff)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic ne, input logic we, input logic oe,
                     input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; ne_n = ne; ce_n = 1'b0; we_n = we; oe_n = oe;
    repeat (2) @(negedge clk);
    ne_n = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (store) begin c_st++;  lat = i; end
      if (aon)   begin c_on++;  lat = i; end
      if (aoff)  begin c_off++; lat = i; end
    end
  endtask

  task automatic pw(input logic [8:0] a, input logic [7:0] d);
    bus(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic ram_wr();
    bus(1'b1, 1'b0, 1'b1, 9'h000, 8'h00);
  endtask

  task automatic recall();
    bus(1'b0, 1'b1, 1'b0, 9'h000, 8'h00);
  endtask

  task automatic clr();
    c_st = 0; c_on = 0; c_off = 0; lat = 0;
  endtask

  function automatic int code();
    return c_st * 100 + c_on * 10 + c_off;
  endfunction

  task automatic key(input logic [8:0] a1, input logic [7:0] d1,
                     input logic [8:0] a2, input logic [7:0] d2,
                     input logic [8:0] a3, input logic [7:0] d3);
    clr();
    pw(a1, d1); pw(a2, d2); pw(a3, d3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int exp;
    rst_n = 1'b0; ne_n = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; data = '0;
    repeat (5) @(negedge clk);
    // R1 outputs quiet in and just after reset
    chk({store, aon, aoff} == 3'b000, "R1", {store, aon, aoff}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({store, aon, aoff} == 3'b000, "R1", {store, aon, aoff}, 0);

    // R4 store before any RAM write is dropped (also R1: no write on record)
    key(9'h155, 8'hAA, 9'h0AA, 8'h55, 9'h155, 8'h33);
    chk(code() == 0, "R4", code(), 0);
    // R3 enable needs no RAM write
    key(9'h155, 8'hAA, 9'h0AA, 8'h55, 9'h155, 8'hCC);
    chk(code() == 10, "R3", code(), 10);
    ram_wr();
    // R2 store with latency R9
    key(9'h155, 8'hAA, 9'h0AA, 8'h55, 9'h155, 8'h33);
    chk(code() == 100, "R2", code(), 100);
    chk(lat == 3, "R9", lat, 3);
    // R3 disable
    key(9'h155, 8'hAA, 9'h0AA, 8'h55, 9'h155, 8'hCD);
    chk(code() == 1, "R3", code(), 1);
    chk(lat == 3, "R9", lat, 3);
    // R6 repeated first step
    clr(); pw(9'h155, 8'hAA);
    key(9'h155, 8'hAA, 9'h0AA, 8'h55, 9'h155, 8'h33);
    chk(code() == 100, "R6", code(), 100);
    // R6 first-step pair at step three restarts
    clr();
    pw(9'h155, 8'hAA); pw(9'h0AA, 8'h55); pw(9'h155, 8'hAA);
    pw(9'h0AA, 8'h55); pw(9'h155, 8'hCC);
    chk(code() == 10, "R6", code(), 10);
    // R7 right data at wrong third address
    key(9'h155, 8'hAA, 9'h0AA, 8'h55, 9'h0AA, 8'h33);
    chk(code() == 0, "R7", code(), 0);
    // R5 broken key must restart: wrong step then tail only
    clr(); pw(9'h155, 8'hAA); pw(9'h0AB, 8'h55); pw(9'h0AA, 8'h55); pw(9'h155, 8'h33);
    chk(code() == 0, "R5", code(), 0);
    // R8 RAM write between steps
    clr(); pw(9'h155, 8'hAA); ram_wr(); pw(9'h0AA, 8'h55); pw(9'h155, 8'h33);
    chk(code() == 0, "R8", code(), 0);
    // R8 recall between steps
    clr(); pw(9'h155, 8'hAA); pw(9'h0AA, 8'h55); recall(); pw(9'h155, 8'h33);
    chk(code() == 0, "R8", code(), 0);

    // R5 sweep step-one address
    for (int a = 0; a < 512; a++) begin
      key(a[8:0], 8'hAA, 9'h0AA, 8'h55, 9'h155, 8'h33);
      exp = (a == 'h155) ? 100 : 0;
      chk(code() == exp, "R5", code(), exp);
      ram_wr();
    end
    // R5 sweep step-two data
    for (int d = 0; d < 256; d++) begin
      key(9'h155, 8'hAA, 9'h0AA, d[7:0], 9'h155, 8'hCD);
      exp = (d == 'h55) ? 1 : 0;
      chk(code() == exp, "R5", code(), exp);
      ram_wr();
    end
    // R5 sweep step-one data
    for (int d = 0; d < 256; d++) begin
      key(9'h155, d[7:0], 9'h0AA, 8'h55, 9'h155, 8'hCC);
      exp = (d == 'hAA) ? 10 : 0;
      chk(code() == exp, "R5", code(), exp);
      ram_wr();
    end
    // R7 sweep third data byte, with R9 latency on hits
    for (int d = 0; d < 256; d++) begin
      key(9'h155, 8'hAA, 9'h0AA, 8'h55, 9'h155, d[7:0]);
      exp = (d == 'h33) ? 100 : (d == 'hCC) ? 10 : (d == 'hCD) ? 1 : 0;
      chk(code() == exp, "R7", code(), exp);
      if (exp != 0) chk(lat == 3, "R9", lat, 3);
      ram_wr();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule